// File: doc/BRIEF.md
# Receive Byte Queue with Error Tags and Idle Timeout

This block sits between a serial deserializer and the host in a UART-style receiver. Each character the deserializer completes is pushed, together with its three error tags (parity, framing, break), into a sixteen-entry first-in first-out store. The oldest entry is always presented to the host as the receive holding value. The tag outputs always describe that same head byte, so when the host pops a byte the error status moves on to the next byte with it.

Two interrupt sources tell the host when to read. The data interrupt fires either on any stored character or only once the fill level reaches a selectable threshold. The idle-timeout interrupt fires when bytes sit below that threshold and nothing has been pushed or read for a span of bit times. That span depends on the configured character length. A push that finds the store full is discarded and sets a sticky overrun flag, which a status read clears.

Top module: `rx_byte_queue`

## Requirements
- R1: The store holds up to 16 entries. `fill_level` counts the stored entries, it is 0 after reset, and it never exceeds 16. A push (`push_valid` high for one clock) into a store that is not full adds one entry at that edge.
- R2: `head_data` shows the oldest stored byte, and `data_ready` is high whenever `fill_level` is non-zero. When the store is empty, `head_data`, `head_tags` and `data_ready` are all 0. A pop (`rd_pop`) removes the head at the edge, and the next oldest byte is presented right after that edge.
- R3: `head_tags` carries the tags pushed with the head byte: bit 0 parity error, bit 1 framing error, bit 2 break. It changes to the next byte's tags in the same cycle as `head_data`.
- R4: A push that arrives while `fill_level` is 16 at the edge is dropped, even if a pop occurs in the same cycle. It sets `overrun` from the next cycle on. `overrun` stays set until a clock with `stat_rd` high and no dropped push; at such a clock it clears.
- R5: With `cfg_trig_en` low and `cfg_ie_rx` high, `irq_data` equals `data_ready`.
- R6: With `cfg_trig_en` high and `cfg_ie_rx` high, `irq_data` is high when `fill_level` is at least the level that `cfg_trig_sel` selects: code 0 selects 1, code 1 selects 4, code 2 selects 8, code 3 selects 14.
- R7: With `cfg_ie_rx` low, both `irq_data` and `irq_tmo` are low.
- R8: Every sixteenth `tick16` pulse counts one bit time. The idle limit is 4×(5+`cfg_wlen`)+12 bit times, so `cfg_wlen` values 0 to 3 give 32, 36, 40 and 44. Once that many bit times have passed with the store non-empty and with no push and no pop, `irq_tmo` rises at the following clock, provided `cfg_ie_rx` is high.
- R9: Any push (accepted or dropped), any pop, and an empty store each restart the bit-time count. A pop also clears the timeout condition at that edge.
- R10: A pop while the store is empty is ignored: `fill_level` stays 0 and the outputs stay at their empty values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | Pulse at sixteen times the bit rate |
| push_valid | input | 1 | Deserializer offers a character this cycle |
| push_data | input | 8 | Character byte |
| push_tags | input | 3 | Error tags: bit 0 parity, bit 1 framing, bit 2 break |
| rd_pop | input | 1 | Host reads and removes the head byte |
| stat_rd | input | 1 | Host reads status; clears overrun |
| cfg_trig_en | input | 1 | 0: interrupt per character, 1: threshold mode |
| cfg_trig_sel | input | 2 | Threshold code (1, 4, 8, 14 entries) |
| cfg_wlen | input | 2 | Character length code, 5 to 8 bits |
| cfg_ie_rx | input | 1 | Enable for both receive interrupts |
| head_data | output | 8 | Oldest stored byte |
| head_tags | output | 3 | Error tags of the oldest byte |
| data_ready | output | 1 | Store is not empty |
| fill_level | output | 5 | Number of stored entries |
| overrun | output | 1 | Sticky overrun flag |
| irq_data | output | 1 | Data-ready interrupt |
| irq_tmo | output | 1 | Idle-timeout interrupt |

## Verification
The fill level, the head byte and its tags, and the overrun flag all update one clock after a push, pop or status read. The interrupt outputs also follow the configuration inputs with no delay in the same cycle. The timeout flag rises one clock after the bit-time count reaches its limit. That point depends on how `tick16` was spaced since the last push or pop. The reference model in the bench advances at each rising edge from the inputs the bench drove at the preceding falling edge. Every output is compared with the model at the falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/rxq_pkg.sv
// Shared types and helper functions for the receive byte queue.
// Assumes an 8-bit character and three error tags per entry.
package rxq_pkg;

    localparam int TAG_W  = 3;
    localparam int DATA_W = 8;

    // One stored character with its error tags (break, framing, parity).
    typedef struct packed {
        logic [TAG_W-1:0]  tags;
        logic [DATA_W-1:0] data;
    } rxq_entry_t;

    // Fill threshold for a 2-bit trigger code, scaled to the store depth.
    function automatic int trig_level(input logic [1:0] code, input int depth);
        case (code)
            2'd0:    return 1;
            2'd1:    return depth / 4;
            2'd2:    return depth / 2;
            default: return depth - 2;
        endcase
    endfunction

    // Idle limit in bit times: four characters of (5+wlen) bits plus twelve.
    function automatic logic [5:0] idle_limit(input logic [1:0] wlen);
        return 6'd32 + {2'b00, wlen, 2'b00};
    endfunction

endpackage

// File: rtl/rxq_store.sv
// Circular entry store with a head output that reads zero when empty.
// Assumes the caller never asserts wr_en when full or rd_en when empty.
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  rxq_entry_t                   wr_entry,
    input  logic                         rd_en,
    output rxq_entry_t                   head,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    rxq_entry_t    mem [DEPTH];
    logic [PW-1:0] wptr;
    logic [PW-1:0] rptr;

    // Write the incoming entry into the slot at the write pointer.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wptr] <= wr_entry;
        end
    end

    // Advance pointers with wrap and track the entry count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (wr_en) begin
                wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            end
            if (rd_en) begin
                rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
            end
            count <= count + CW'(wr_en) - CW'(rd_en);
        end
    end

    // Present the oldest entry, or zero when nothing is stored.
    always_comb begin
        head = (count != '0) ? mem[rptr] : '0;
    end

endmodule

// File: rtl/rxq_timer.sv
// Idle timer counting bit times from the 16x tick.
// Assumes restart is raised on every push, every pop and while empty.
module rxq_timer
    import rxq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic       restart,
    input  logic       nonempty,
    input  logic       clear,
    input  logic [1:0] wlen,
    output logic       tmo_flag
);
    logic [3:0] sub_cnt;
    logic [5:0] bit_cnt;
    logic [5:0] limit;

    // Current limit from the character length code.
    always_comb begin
        limit = idle_limit(wlen);
    end

    // Divide the tick by sixteen and count whole bit times, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            sub_cnt <= '0;
            bit_cnt <= '0;
        end else if (tick16) begin
            if (sub_cnt == 4'hF) begin
                sub_cnt <= '0;
                if (bit_cnt < limit) begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end else begin
                sub_cnt <= sub_cnt + 1'b1;
            end
        end
    end

    // Latch the timeout once the limit is reached with data waiting; a read clears it.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            tmo_flag <= 1'b0;
        end else if (nonempty && (bit_cnt >= limit)) begin
            tmo_flag <= 1'b1;
        end
    end

endmodule

// File: rtl/rxq_irq.sv
// Interrupt gating: per-character or threshold data interrupt, and timeout.
// Assumes count is the current stored-entry count.
module rxq_irq
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic [$clog2(DEPTH+1)-1:0] count,
    input  logic                       trig_en,
    input  logic [1:0]                 trig_sel,
    input  logic                       ie,
    input  logic                       tmo_flag,
    output logic                       irq_data,
    output logic                       irq_tmo
);
    logic reached;

    // Decide whether the data interrupt condition holds in the selected mode.
    always_comb begin
        if (trig_en) begin
            reached = int'(count) >= trig_level(trig_sel, DEPTH);
        end else begin
            reached = (count != '0);
        end
        irq_data = ie && reached;
        irq_tmo  = ie && tmo_flag;
    end

endmodule

// File: rtl/rx_byte_queue.sv
// Receive byte queue: stores characters with error tags, shows the head byte
// and its tags to the host, flags overrun, raises data and idle interrupts.
// Assumes one push per clock at most and a single-cycle tick16 pulse.
module rx_byte_queue
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick16,
    input  logic                       push_valid,
    input  logic [7:0]                 push_data,
    input  logic [2:0]                 push_tags,
    input  logic                       rd_pop,
    input  logic                       stat_rd,
    input  logic                       cfg_trig_en,
    input  logic [1:0]                 cfg_trig_sel,
    input  logic [1:0]                 cfg_wlen,
    input  logic                       cfg_ie_rx,
    output logic [7:0]                 head_data,
    output logic [2:0]                 head_tags,
    output logic                       data_ready,
    output logic [$clog2(DEPTH+1)-1:0] fill_level,
    output logic                       overrun,
    output logic                       irq_data,
    output logic                       irq_tmo
);
    localparam int CW = $clog2(DEPTH + 1);

    logic          full;
    logic          empty;
    logic          wr_en;
    logic          rd_en;
    logic          tmo_flag;
    rxq_entry_t    in_entry;
    rxq_entry_t    head;
    logic [CW-1:0] count;

    // Accept pushes only when room exists and pops only when data exists.
    always_comb begin
        full          = (count == CW'(DEPTH));
        empty         = (count == '0);
        wr_en         = push_valid && !full;
        rd_en         = rd_pop && !empty;
        in_entry.data = push_data;
        in_entry.tags = push_tags;
    end

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_entry (in_entry),
        .rd_en    (rd_en),
        .head     (head),
        .count    (count)
    );

    rxq_timer u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick16   (tick16),
        .restart  (push_valid || rd_pop || empty),
        .nonempty (!empty),
        .clear    (rd_pop),
        .wlen     (cfg_wlen),
        .tmo_flag (tmo_flag)
    );

    rxq_irq #(.DEPTH(DEPTH)) u_irq (
        .count    (count),
        .trig_en  (cfg_trig_en),
        .trig_sel (cfg_trig_sel),
        .ie       (cfg_ie_rx),
        .tmo_flag (tmo_flag),
        .irq_data (irq_data),
        .irq_tmo  (irq_tmo)
    );

    // Sticky overrun: set by a dropped push, cleared by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun <= 1'b0;
        end else if (push_valid && full) begin
            overrun <= 1'b1;
        end else if (stat_rd) begin
            overrun <= 1'b0;
        end
    end

    // Drive host-visible outputs from the store.
    always_comb begin
        head_data  = head.data;
        head_tags  = head.tags;
        data_ready = !empty;
        fill_level = count;
    end

endmodule

// File: rtl/rxq_checker.sv
// Temporal checks on the receive byte queue ports, bound to the top module.
module rxq_checker #(
    parameter int DEPTH = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       push_valid,
    input logic                       rd_pop,
    input logic                       stat_rd,
    input logic                       cfg_trig_en,
    input logic                       cfg_ie_rx,
    input logic [7:0]                 head_data,
    input logic [2:0]                 head_tags,
    input logic                       data_ready,
    input logic [$clog2(DEPTH+1)-1:0] fill_level,
    input logic                       overrun,
    input logic                       irq_data,
    input logic                       irq_tmo
);
    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fill_level) <= DEPTH); // R1
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(fill_level) == DEPTH && push_valid && !rd_pop) |=> (int'(fill_level) == DEPTH && overrun)); // R4
    AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !stat_rd) |=> overrun); // R4
    AST_EMPTY_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_level == '0) |-> (head_data == '0 && head_tags == '0 && !data_ready)); // R2
    AST_PER_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ie_rx && !cfg_trig_en) |-> (irq_data == data_ready)); // R5
    AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ie_rx |-> (!irq_data && !irq_tmo)); // R7
    AST_TMO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pop |=> !irq_tmo); // R9
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_level == '0 && rd_pop && !push_valid) |=> (fill_level == '0)); // R10
endmodule

bind rx_byte_queue rxq_checker #(.DEPTH(DEPTH)) u_rxq_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_valid  (push_valid),
    .rd_pop      (rd_pop),
    .stat_rd     (stat_rd),
    .cfg_trig_en (cfg_trig_en),
    .cfg_ie_rx   (cfg_ie_rx),
    .head_data   (head_data),
    .head_tags   (head_tags),
    .data_ready  (data_ready),
    .fill_level  (fill_level),
    .overrun     (overrun),
    .irq_data    (irq_data),
    .irq_tmo     (irq_tmo)
);

// File: tb/test_rx_byte_queue.sv
`timescale 1ns/1ps
// Bench: behavioural queue model advanced each rising edge, compared each falling edge.
module test_rx_byte_queue;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       push_valid = 1'b0;
    logic [7:0] push_data = '0;
    logic [2:0] push_tags = '0;
    logic       rd_pop = 1'b0;
    logic       stat_rd = 1'b0;
    logic       cfg_trig_en = 1'b0;
    logic [1:0] cfg_trig_sel = '0;
    logic [1:0] cfg_wlen = '0;
    logic       cfg_ie_rx = 1'b1;
    logic [7:0] head_data;
    logic [2:0] head_tags;
    logic       data_ready;
    logic [4:0] fill_level;
    logic       overrun;
    logic       irq_data;
    logic       irq_tmo;

    int tests = 0;
    int fails = 0;
    int cyc_n = 0;

    // Model state
    logic [10:0] mq[$];
    int  m_sub, m_bits, m_lim;
    bit  m_tmo, m_ovr, m_empty, m_full, m_ge;

    always #4 clk = ~clk;

    rx_byte_queue i_rx_byte_queue (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .push_valid(push_valid),
        .push_data(push_data), .push_tags(push_tags), .rd_pop(rd_pop),
        .stat_rd(stat_rd), .cfg_trig_en(cfg_trig_en), .cfg_trig_sel(cfg_trig_sel),
        .cfg_wlen(cfg_wlen), .cfg_ie_rx(cfg_ie_rx), .head_data(head_data),
        .head_tags(head_tags), .data_ready(data_ready), .fill_level(fill_level),
        .overrun(overrun), .irq_data(irq_data), .irq_tmo(irq_tmo)
    );

    // Reference model update from the inputs driven before this edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            m_sub = 0; m_bits = 0; m_tmo = 0; m_ovr = 0;
        end else begin
            m_lim   = 32 + 4 * int'(cfg_wlen);
            m_empty = (mq.size() == 0);
            m_full  = (mq.size() == 16);
            m_ge    = (m_bits >= m_lim);
            if (push_valid || rd_pop || m_empty) begin
                m_sub = 0; m_bits = 0;
            end else if (tick16) begin
                if (m_sub == 15) begin
                    m_sub = 0;
                    if (m_bits < m_lim) m_bits++;
                end else m_sub++;
            end
            if (rd_pop) m_tmo = 0;
            else if (!m_empty && m_ge) m_tmo = 1;
            if (rd_pop && !m_empty) void'(mq.pop_front());
            if (push_valid) begin
                if (!m_full) mq.push_back({push_tags, push_data});
                else m_ovr = 1;
            end
            if (stat_rd && !(push_valid && m_full)) m_ovr = 0;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc_n, act, exp);
        end
    endtask

    function automatic int lvl(input logic [1:0] c);
        case (c)
            2'd0: return 1;
            2'd1: return 4;
            2'd2: return 8;
            default: return 14;
        endcase
    endfunction

    // Compare every output with the model.
    task automatic compare_all();
        int n = mq.size();
        int e_hd = (n > 0) ? int'(mq[0][7:0]) : 0;
        int e_ht = (n > 0) ? int'(mq[0][10:8]) : 0;
        int e_id = cfg_ie_rx && (cfg_trig_en ? (n >= lvl(cfg_trig_sel)) : (n >= 1));
        chk("R1 fill_level", int'(fill_level), n);
        chk("R2 head_data", int'(head_data), e_hd);
        chk("R2 data_ready", int'(data_ready), int'(n > 0));
        chk("R3 head_tags", int'(head_tags), e_ht);
        chk("R4 overrun", int'(overrun), int'(m_ovr));
        chk("R5 R6 R7 irq_data", int'(irq_data), e_id);
        chk("R8 R9 irq_tmo", int'(irq_tmo), int'(cfg_ie_rx && m_tmo));
    endtask

    // One clock: check at the falling edge, then drive the next inputs.
    task automatic cyc(input bit p, input logic [7:0] d, input logic [2:0] t,
                       input bit r, input bit s);
        @(negedge clk);
        if (rst_n) compare_all();
        cyc_n++;
        push_valid = p; push_data = d; push_tags = t;
        rd_pop = r; stat_rd = s;
        tick16 = (cyc_n % 2 == 0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
    endtask

    initial begin
        #(200000 * 8);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        idle(3);
        @(negedge clk); rst_n = 1'b1;
        // R1 reset state
        idle(2);
        // R2 R3 R5 per-character mode, varied tags
        cyc(1, 8'hA5, 3'b001, 0, 0);
        cyc(1, 8'h3C, 3'b010, 0, 0);
        cyc(1, 8'hFF, 3'b100, 0, 0);
        idle(2);
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, 0);
        idle(2);
        // R10 pop on empty
        cyc(0, 0, 0, 1, 0);
        cyc(0, 0, 0, 1, 0);
        @(negedge clk); cyc_n++;
        push_valid = 0; rd_pop = 0;
        chk("R10 pop on empty", int'(fill_level), 0);
        chk("R10 empty head", int'(head_data), 0);
        // R4 fill, overflow, pop with full drop, status clear
        for (int i = 0; i < 16; i++) cyc(1, 8'(i + 16), 3'(i), 0, 0);
        cyc(1, 8'h77, 3'b111, 0, 0);
        cyc(1, 8'h78, 3'b111, 1, 0);
        idle(3);
        cyc(1, 8'h79, 0, 0, 1);
        idle(2);
        cyc(0, 0, 0, 0, 1);
        idle(2);
        for (int i = 0; i < 16; i++) cyc(0, 0, 0, 1, 0);
        idle(2);
        // R6 threshold mode for each code
        cfg_trig_en = 1'b1;
        for (int c = 0; c < 4; c++) begin
            cfg_trig_sel = 2'(c);
            for (int i = 0; i < 15; i++) cyc(1, 8'(c * 20 + i), 3'(i), 0, 0);
            for (int i = 0; i < 15; i++) cyc(0, 0, 0, 1, 0);
        end
        // R7 masking with data and threshold reached
        cfg_ie_rx = 1'b0;
        for (int i = 0; i < 5; i++) cyc(1, 8'(i), 0, 0, 0);
        idle(1200);
        for (int i = 0; i < 5; i++) cyc(0, 0, 0, 1, 0);
        cfg_ie_rx = 1'b1;
        cfg_trig_sel = 2'd3;
        // R8 R9 timeout for each character length
        for (int w = 0; w < 4; w++) begin
            cfg_wlen = 2'(w);
            cyc(1, 8'(w + 1), 3'b010, 0, 0);
            idle(500);
            cyc(1, 8'(w + 9), 0, 0, 0);
            idle(1500);
            cyc(0, 0, 0, 1, 0);
            idle(1500);
            cyc(0, 0, 0, 1, 0);
            idle(4);
        end
        idle(2);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule